// File: doc/BRIEF.md
# Trace Sync-Interval Byte Pacer

This block sits beside the output stream of a trace aggregator. It counts the bytes that leave the stream and asks for an alignment (ASYNC) packet each time a programmed number of bytes has gone by. A downstream parser that loses its place can then find packet boundaries again at a known spacing. The block does not build the packet, and it takes no part in arbitration. It only counts and raises a one-cycle request.

The block has one 13-bit control register. It is written through a single-cycle write strobe and can always be read back. The low twelve bits hold a count field and bit 12 selects the threshold mode:

- **Linear mode (bit 12 = 0):** the count field is the byte interval.
- **Exponent mode (bit 12 = 1):** the top five bits of the count field, bits [11:7], are a power-of-two exponent.

Software normally writes the register once when tracing is enabled. A write with the mode bit clear throws away any count left over from an earlier session, so the first request never comes early. The data path gives a byte count of 0 to 8 for each cycle, together with a clock enable.

Top module: `trace_sync_pacer`

## Requirements
- R1: After an active-low reset, `syncReq` is low, `regRdData` reads 0, and no request is raised for any byte stream until the register is written.
- R2: A write with `regWrEn` high stores `regWrData` (count field in bits [11:0], mode bit at bit 12). `regRdData` shows the stored value from the next cycle on.
- R3: In linear mode, a request is raised on every beat in which the bytes accumulated since the last request reach or exceed the count field. A count field of zero raises no request at all.
- R4: In exponent mode, the interval is 2^E bytes, where E = count[11:7]. Bits [6:0] have no effect. An E above 15 is treated as 15, which gives an interval of 32768 bytes.
- R5: `syncReq` is high for exactly the one cycle that follows the beat whose bytes reach the threshold. At most one request is raised per beat, even when the threshold is crossed in the middle of a beat.
- R6: After a request, counting restarts from the excess bytes of that beat (sum minus interval). The excess is limited to interval minus 1.
- R7: A write with bit 12 clear sets the running count to zero. Any bytes offered in the same cycle are discarded.
- R8: A write with bit 12 set keeps the running count. Only the interval changes.
- R9: While `clkEn` is low, offered bytes are ignored, the count holds, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkEn | input | 1 | Counting enable for this cycle |
| byteCount | input | 4 | Bytes leaving the aggregator this cycle (0 to 8) |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 13 | Control register write value |
| regRdData | output | 13 | Control register readback |
| syncReq | output | 1 | One-cycle ASYNC packet request |

## Verification
The hardest state to reach is a counter that holds a partial, non-zero count at the exact moment the register is rewritten. Only that state shows whether a linear-mode write clears the count while an exponent-mode write keeps it. The stimulus feeds a measured number of bytes that stays just under the interval, rewrites the register, and then feeds exactly the remaining bytes, so that the presence or absence of a request shows the count that survived. Crossing the threshold in the middle of a beat and the capped excess are reached by mixing random beat sizes with intervals smaller than one beat.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int CNT_W    = 12;            // count field width
  localparam int MODE_POS = CNT_W;         // mode bit position
  localparam int REG_W    = CNT_W + 1;     // control register width
  localparam int EXP_W    = 5;             // exponent field width
  localparam int BYTE_W   = 4;             // per-beat byte count width
  localparam int ACC_W    = 17;            // running counter width
  localparam int MAX_EXP  = ACC_W - 2;     // largest exponent honoured

  typedef struct packed {
    logic             clear;    // zero the running count
    logic             advance;  // accept this beat's bytes
    logic             enable;   // request generation allowed
    logic [ACC_W-1:0] limit;    // interval in bytes
  } pacer_cmd_t;
endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output pacer_cmd_t       cmd
);
  localparam logic [EXP_W-1:0] MAX_EXP_V = EXP_W'(MAX_EXP);

  logic [REG_W-1:0] ctrlReg;
  logic [EXP_W-1:0] expField;
  logic [EXP_W-1:0] expSat;
  logic             clearNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlReg <= '0;
    else if (regWrEn) ctrlReg <= regWrData;
  end

  assign clearNow  = regWrEn && !regWrData[MODE_POS];
  assign regRdData = ctrlReg;
  assign expField  = ctrlReg[CNT_W-1 -: EXP_W];
  assign expSat    = (expField > MAX_EXP_V) ? MAX_EXP_V : expField;

  always_comb begin
    cmd         = '0;
    cmd.clear   = clearNow;
    cmd.advance = clkEn && !clearNow;
    if (ctrlReg[MODE_POS]) begin
      cmd.limit  = ACC_W'(1) << expSat;
      cmd.enable = 1'b1;
    end else begin
      cmd.limit  = ACC_W'(ctrlReg[CNT_W-1:0]);
      cmd.enable = |ctrlReg[CNT_W-1:0];
    end
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) |-> regRdData == $past(regWrData));

  // R4
  exp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[MODE_POS] |-> $countones(cmd.limit) == 1);
endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pacer_cmd_t        cmd,
  input  logic [BYTE_W-1:0] byteCount,
  output logic              syncReq
);
  logic [ACC_W-1:0] runCnt;
  logic [ACC_W-1:0] nextCnt;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   excess;
  logic [ACC_W:0]   limitW;
  logic             hit;
  logic             counting;

  assign limitW   = {1'b0, cmd.limit};
  assign sum      = {1'b0, runCnt} + (ACC_W+1)'(byteCount);
  assign excess   = sum - limitW;
  assign counting = cmd.advance && cmd.enable;
  assign hit      = counting && (sum >= limitW);

  always_comb begin
    nextCnt = runCnt;
    if (cmd.clear)         nextCnt = '0;
    else if (hit)          nextCnt = (excess >= limitW) ? cmd.limit - ACC_W'(1)
                                                        : excess[ACC_W-1:0];
    else if (counting)     nextCnt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      syncReq <= 1'b0;
    end else begin
      runCnt  <= nextCnt;
      syncReq <= hit;
    end
  end

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.clear) |-> runCnt == '0);

  // R5
  req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |-> $past(cmd.advance && cmd.enable));

  // R6
  remainder_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |-> runCnt < $past(cmd.limit));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(cmd.advance && cmd.enable) && !cmd.clear) |-> runCnt == $past(runCnt));
endmodule

// File: rtl/trace_sync_pacer.sv
module trace_sync_pacer
  import pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              syncReq
);
  pacer_cmd_t cmd;

  pacer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cmd(cmd)
  );

  pacer_datapath uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .byteCount(byteCount), .syncReq(syncReq)
  );
endmodule

// File: tb/tb_trace_sync_pacer.sv
`timescale 1ns/1ps
module tb_trace_sync_pacer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic [3:0]  byteCount = '0;
  logic        regWrEn = 1'b0;
  logic [12:0] regWrData = '0;
  logic [12:0] regRdData;
  logic        syncReq;

  int  total = 0;
  int  bad = 0;
  int  refCnt = 0;
  int  refCount = 0;
  bit  refMode = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  trace_sync_pacer dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .byteCount(byteCount),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .syncReq(syncReq)
  );

  function automatic int refLimit();
    int e;
    if (refMode) begin
      e = refCount >> 7;
      if (e > 15) e = 15;
      return 1 << e;
    end
    return refCount;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic writeReg(logic [12:0] data);
    regWrEn = 1'b1; regWrData = data; clkEn = 1'b0; byteCount = '0;
    @(negedge clk);
    regWrEn = 1'b0;
    refCount = int'(data[11:0]);
    refMode  = data[12];
    if (!refMode) refCnt = 0;
    check(regRdData == data, "R2 readback", int'(regRdData), int'(data));
  endtask

  // One beat; compares syncReq with the model every cycle; returns the pulse.
  task automatic beat(int b, bit en, string req, output bit got);
    int  lim;
    int  s;
    bit  exp;
    byteCount = 4'(b); clkEn = en;
    lim = refLimit();
    exp = 1'b0;
    if (en && (refMode || refCount != 0)) begin
      s = refCnt + b;
      if (s >= lim) begin
        exp = 1'b1;
        refCnt = (s - lim >= lim) ? lim - 1 : s - lim;
      end else refCnt = s;
    end
    @(negedge clk);
    got = syncReq;
    check(syncReq == exp, req, int'(syncReq), int'(exp));
    byteCount = '0; clkEn = 1'b0;
  endtask

  // mode 0: constant bytes, 1: random 0..8
  task automatic run(int n, int b, bit rnd, bit en, string req, output int pulses);
    bit g;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      beat(rnd ? int'($urandom_range(8, 0)) : b, en, req, g);
      if (g) pulses++;
    end
  endtask

  task automatic testReset();
    int p;
    check(syncReq == 1'b0, "R1 req after reset", int'(syncReq), 0);
    check(regRdData == '0, "R1 reg after reset", int'(regRdData), 0);
    run(40, 8, 1'b0, 1'b1, "R1 no request before write", p);
    check(p == 0, "R1 pulse count", p, 0);
  endtask

  task automatic testLinear();
    int p;
    writeReg(13'd100);
    run(250, 8, 1'b0, 1'b1, "R3 linear constant", p);
    check(p == 20, "R3 linear pulse count", p, 20);
    writeReg(13'd37);
    run(400, 0, 1'b1, 1'b1, "R3 linear random", p);
    writeReg(13'd0);
    run(60, 8, 1'b0, 1'b1, "R3 zero disables", p);
    check(p == 0, "R3 zero count pulses", p, 0);
  endtask

  task automatic testMidWord();
    bit g;
    writeReg(13'd10);
    beat(7, 1'b1, "R5 below threshold", g);
    beat(7, 1'b1, "R5 crossing mid-beat", g);
    check(g == 1'b1, "R5 single pulse at crossing", int'(g), 1);
    beat(0, 1'b1, "R5 pulse lasts one cycle", g);
    check(g == 1'b0, "R5 pulse drops", int'(g), 0);
    beat(5, 1'b1, "R6 excess of 4 carried", g);
    check(g == 1'b0, "R6 9 bytes no pulse", int'(g), 0);
    beat(1, 1'b1, "R6 excess reaches 10", g);
    check(g == 1'b1, "R6 carried excess fires", int'(g), 1);
  endtask

  task automatic testClamp();
    int p;
    bit g;
    writeReg(13'd3);
    run(20, 8, 1'b0, 1'b1, "R6 small interval", p);
    check(p == 20, "R6 one pulse per beat", p, 20);
    beat(2, 1'b1, "R6 capped excess then 2", g);
    check(g == 1'b1, "R6 cap at interval-1", int'(g), 1);
  endtask

  task automatic testExponent();
    int p;
    writeReg({1'b1, 5'd13, 7'h55});
    run(1023, 8, 1'b0, 1'b1, "R4 exp13 lead", p);
    check(p == 0, "R4 no pulse before 8192", p, 0);
    run(1, 8, 1'b0, 1'b1, "R4 exp13 at 8192", p);
    check(p == 1, "R4 pulse at 8192", p, 1);
    run(1024, 8, 1'b0, 1'b1, "R4 exp13 second", p);
    check(p == 1, "R4 steady spacing", p, 1);
    writeReg({1'b1, 5'd31, 7'h00});
    run(4095, 8, 1'b0, 1'b1, "R4 saturated lead", p);
    check(p == 0, "R4 no pulse before 32768", p, 0);
    run(1, 8, 1'b0, 1'b1, "R4 saturated at 32768", p);
    check(p == 1, "R4 saturated pulse", p, 1);
    writeReg({1'b1, 5'd4, 7'h00});
    run(300, 0, 1'b1, 1'b1, "R4 exp4 random", p);
  endtask

  task automatic testClearAndKeep();
    int p;
    writeReg(13'd100);
    run(9, 10, 1'b0, 1'b0, "R9 idle", p);
    run(90, 1, 1'b0, 1'b1, "R7 partial 90", p);
    writeReg(13'd100);
    run(90, 1, 1'b0, 1'b1, "R7 after clear", p);
    check(p == 0, "R7 partial count cleared", p, 0);
    run(10, 1, 1'b0, 1'b1, "R7 completes at 100", p);
    check(p == 1, "R7 pulse after full interval", p, 1);
    writeReg({1'b1, 5'd7, 7'h00});
    run(100, 1, 1'b0, 1'b1, "R8 partial 100", p);
    writeReg({1'b1, 5'd7, 7'h3F});
    run(28, 1, 1'b0, 1'b1, "R8 kept count", p);
    check(p == 1, "R8 count kept across write", p, 1);
  endtask

  task automatic testEnable();
    int p;
    writeReg(13'd16);
    run(15, 1, 1'b0, 1'b1, "R9 partial 15", p);
    run(50, 8, 1'b0, 1'b0, "R9 bytes ignored", p);
    check(p == 0, "R9 no pulse while disabled", p, 0);
    run(1, 1, 1'b0, 1'b1, "R9 count held", p);
    check(p == 1, "R9 held count completes", p, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testMidWord();
    testClamp();
    testExponent();
    testClearAndKeep();
    testEnable();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule